// File: doc/BRIEF.md
# SMBus Register and Non-Volatile Store Command Controller

This block sits behind a byte-level SMBus slave front end and turns its events (start, stop, own-address match with the direction bit, received byte) into accesses to two stores: a volatile register file of 224 bytes at addresses 00h to DFh, and a non-volatile array of 512 bytes at 16-bit addresses F800h to F9FFh, organised as 16 pages of 32 bytes. For every address match and every received byte it answers, one clock later, with an acknowledge or a refusal. On a read-addressed transaction it presents the byte selected by the current pointer.

The first byte of a write transaction is a command byte with several meanings. A value up to DFh is a register address. F0h starts a word write that loads the non-volatile pointer. F1h carries a byte to program at that pointer. FEh erases the page under that pointer. Non-volatile bytes can be programmed only while blank (FFh). An erase clears a whole page. It runs only when bit 3 of the register at 90h is set, it takes a parameterised number of cycles, and every access is refused while it runs.

The non-volatile array is modelled as flops that reset to the blank value. The erase time is the `ERASE_CYCLES` parameter and stands in for the real one.

Top module: `smb_cmd_ctrl`

## Requirements
- R1: After reset, `rsp_valid` and `erase_busy` are 0, every register byte is 00h, every non-volatile byte is FFh, and a read returns register 00h, which is 00h.
- R2: A write-byte transaction (command, one data byte) whose command is at most DFh writes the data byte to that register. A send-byte transaction (command only) with a command at most DFh loads the register pointer and selects the register file, so a later read returns that register.
- R3: Send-byte and write-byte with a command in E0h–FDh other than F0h and F1h change neither the pointer nor any register.
- R4: A write-word transaction (command F0h, then the high address byte, then the low address byte) loads the 16-bit non-volatile pointer and selects the non-volatile array for reads. A blank location reads FFh.
- R5: A write-byte with command F1h programs its data byte at the non-volatile pointer only if that location holds FFh. Otherwise it has no effect.
- R6: When the non-volatile pointer lies outside F800h–F9FFh, reads return 00h and programming has no effect.
- R7: A send-byte with command FEh, while bit 3 of register 90h is 1 and the pointer is in range, starts an erase as soon as that byte is received. `erase_busy` goes high in the cycle after the byte's response and stays high for exactly `ERASE_CYCLES` cycles. All 32 bytes of the pointer's page (address bits 8:5 relative to F800h) become FFh, and other pages keep their contents.
- R8: With bit 3 of register 90h at 0, command FEh starts no erase and changes no data.
- R9: While `erase_busy` is high, every address match and every byte is refused, and a transaction with a refused byte commits nothing.
- R10: Each address match or byte event yields exactly one response with `rsp_valid` high in the next cycle. A byte outside an acknowledged write transaction is refused, and an address match is acknowledged when no erase is running.
- R11: A fourth byte after the address in a write transaction is refused, and the whole transaction is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_start | input | 1 | Start or repeated-start seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop seen (one-cycle pulse) |
| ev_addr | input | 1 | Own slave address matched (one-cycle pulse) |
| ev_rw | input | 1 | Direction bit qualifying `ev_addr`, 1 = read |
| ev_byte | input | 1 | A byte was received from the master (one-cycle pulse) |
| rx_data | input | 8 | Received byte qualifying `ev_byte` |
| rsp_valid | output | 1 | Response decision is valid this cycle |
| rsp_ack | output | 1 | 1 = acknowledge, 0 = refuse |
| tx_data | output | 8 | Byte to transmit, loaded on an acknowledged read address match |
| erase_busy | output | 1 | A page erase is in progress |

## Verification
The bench builds the block with `ERASE_CYCLES` set to 64 instead of a default sized for a wall-clock erase. This makes the whole busy window short enough to count cycle by cycle, to probe with refused accesses in the middle, and to follow with reads of the cleared page and of an untouched page. Every other parameter keeps its default, so the real address map (the DFh register limit, the F800h–F9FFh window and the 32-byte pages) is exercised, including pointers just outside the window.

// File: rtl/smb_cmd_pkg.sv
package smb_cmd_pkg;

  localparam int RAM_BYTES  = 224;
  localparam int NV_PAGES   = 16;
  localparam int PAGE_BYTES = 32;
  localparam int NV_BYTES   = NV_PAGES * PAGE_BYTES;
  localparam int PAGE_W     = $clog2(NV_PAGES);
  localparam int OFS_W      = $clog2(PAGE_BYTES);
  localparam int NV_IDX_W   = PAGE_W + OFS_W;

  localparam logic [7:0]  RAM_TOP    = 8'hDF;
  localparam logic [7:0]  CMD_NVPTR  = 8'hF0;
  localparam logic [7:0]  CMD_NVPROG = 8'hF1;
  localparam logic [7:0]  CMD_ERASE  = 8'hFE;
  localparam logic [7:0]  CFG_ADDR   = 8'h90;
  localparam int          CFG_BIT    = 3;
  localparam logic [15:0] NV_BASE    = 16'hF800;
  localparam logic [15:0] NV_LAST    = NV_BASE + 16'(NV_BYTES - 1);
  localparam logic [7:0]  BLANK      = 8'hFF;

  typedef enum logic [1:0] {
    LEN_NONE = 2'd0,
    LEN_SEND = 2'd1,
    LEN_BYTE = 2'd2,
    LEN_WORD = 2'd3
  } xlen_t;

endpackage

// File: rtl/smb_xact_track.sv
module smb_xact_track
  import smb_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_addr,
  input  logic       ev_rw,
  input  logic       ev_byte,
  input  logic [7:0] rx_data,
  input  logic       busy,
  input  logic       erase_ok,
  output logic       rsp_valid,
  output logic       rsp_ack,
  output logic       erase_req,
  output logic       cmt_valid,
  output xlen_t      cmt_len,
  output logic [7:0] cmt_cmd,
  output logic [7:0] cmt_d0,
  output logic [7:0] cmt_d1
);

  logic       wr_q, wr_n;
  logic       ab_q, ab_n;
  logic [1:0] cnt_q, cnt_n;
  logic [7:0] cmd_q, cmd_n, d0_q, d0_n, d1_q, d1_n;
  logic       rv_n, ra_n, er_n, cv_n;

  always_comb begin
    wr_n  = wr_q;
    ab_n  = ab_q;
    cnt_n = cnt_q;
    cmd_n = cmd_q;
    d0_n  = d0_q;
    d1_n  = d1_q;
    rv_n  = ev_addr | ev_byte;
    ra_n  = 1'b0;
    er_n  = 1'b0;
    cv_n  = 1'b0;
    if (ev_start) begin
      wr_n  = 1'b0;
      ab_n  = 1'b0;
      cnt_n = 2'd0;
    end
    if (ev_addr) begin
      ra_n  = !busy;
      wr_n  = !busy && !ev_rw;
      ab_n  = 1'b0;
      cnt_n = 2'd0;
    end
    if (ev_byte) begin
      if (busy) begin
        ab_n = 1'b1;
      end else if (wr_q && !ab_q) begin
        if (cnt_q == 2'd3) begin
          ab_n = 1'b1;
        end else begin
          ra_n  = 1'b1;
          cnt_n = cnt_q + 2'd1;
          case (cnt_q)
            2'd0:    cmd_n = rx_data;
            2'd1:    d0_n  = rx_data;
            default: d1_n  = rx_data;
          endcase
          if (cnt_q == 2'd0 && rx_data == CMD_ERASE && erase_ok) er_n = 1'b1;
        end
      end
    end
    if (ev_stop) begin
      cv_n = wr_q && !ab_q && (cnt_q != 2'd0);
      wr_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      ab_q      <= 1'b0;
      cnt_q     <= 2'd0;
      cmd_q     <= 8'h00;
      d0_q      <= 8'h00;
      d1_q      <= 8'h00;
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      erase_req <= 1'b0;
      cmt_valid <= 1'b0;
    end else begin
      wr_q      <= wr_n;
      ab_q      <= ab_n;
      cnt_q     <= cnt_n;
      cmd_q     <= cmd_n;
      d0_q      <= d0_n;
      d1_q      <= d1_n;
      rsp_valid <= rv_n;
      rsp_ack   <= ra_n;
      erase_req <= er_n;
      cmt_valid <= cv_n;
    end
  end

  assign cmt_len = xlen_t'(cnt_q);
  assign cmt_cmd = cmd_q;
  assign cmt_d0  = d0_q;
  assign cmt_d1  = d1_q;

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_addr || ev_byte) |=> rsp_valid);
  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_addr || ev_byte) |=> !rsp_valid);
  assert_busy_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (ev_addr || ev_byte)) |=> (rsp_valid && !rsp_ack));
  assert_overrun_nack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte && wr_q && cnt_q == 2'd3) |=> !rsp_ack);

endmodule

// File: rtl/smb_erase_seq.sv
module smb_erase_seq
  import smb_cmd_pkg::*;
#(
  parameter int ERASE_CYCLES = 1000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [PAGE_W-1:0]   page,
  output logic                busy,
  output logic                clr_en,
  output logic [NV_IDX_W-1:0] clr_idx
);

  localparam int CW = $clog2(ERASE_CYCLES + 1);

  logic              busy_q, busy_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [PAGE_W-1:0] page_q, page_n;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    page_n = page_q;
    if (!busy_q && start) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      page_n = page;
    end else if (busy_q) begin
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == CW'(ERASE_CYCLES - 1)) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      page_q <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      page_q <= page_n;
    end
  end

  assign busy    = busy_q;
  assign clr_en  = busy_q && (cnt_q < CW'(PAGE_BYTES));
  assign clr_idx = {page_q, cnt_q[OFS_W-1:0]};

  assert_erase_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CW'(ERASE_CYCLES)));
  assert_erase_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q);

endmodule

// File: rtl/smb_cmd_ctrl.sv
module smb_cmd_ctrl
  import smb_cmd_pkg::*;
#(
  parameter int ERASE_CYCLES = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_addr,
  input  logic       ev_rw,
  input  logic       ev_byte,
  input  logic [7:0] rx_data,
  output logic       rsp_valid,
  output logic       rsp_ack,
  output logic [7:0] tx_data,
  output logic       erase_busy
);

  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic [7:0]  ram_q [RAM_BYTES];
  logic [7:0]  nv_q  [NV_BYTES];
  logic [7:0]  ptr_q;
  logic [15:0] nvp_q;
  logic        sel_nv_q;
  logic [7:0]  tx_q;

  logic                erase_req, erase_ok, cmt_valid, clr_en;
  xlen_t               cmt_len;
  logic [7:0]          cmt_cmd, cmt_d0, cmt_d1;
  logic [NV_IDX_W-1:0] clr_idx, nv_idx;
  logic [15:0]         nv_ofs;
  logic                nv_hit, cfg_en;
  logic                ram_we, ptr_we, nvp_we, nv_pg, tx_we;
  logic [7:0]          rd_val;

  smb_xact_track u_xact (
    .clk      (clk),
    .rst_n    (rst_i),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_addr  (ev_addr),
    .ev_rw    (ev_rw),
    .ev_byte  (ev_byte),
    .rx_data  (rx_data),
    .busy     (erase_busy),
    .erase_ok (erase_ok),
    .rsp_valid(rsp_valid),
    .rsp_ack  (rsp_ack),
    .erase_req(erase_req),
    .cmt_valid(cmt_valid),
    .cmt_len  (cmt_len),
    .cmt_cmd  (cmt_cmd),
    .cmt_d0   (cmt_d0),
    .cmt_d1   (cmt_d1)
  );

  smb_erase_seq #(.ERASE_CYCLES(ERASE_CYCLES)) u_erase (
    .clk    (clk),
    .rst_n  (rst_i),
    .start  (erase_req),
    .page   (nv_idx[NV_IDX_W-1:OFS_W]),
    .busy   (erase_busy),
    .clr_en (clr_en),
    .clr_idx(clr_idx)
  );

  always_comb begin
    nv_hit   = (nvp_q >= NV_BASE) && (nvp_q <= NV_LAST);
    nv_ofs   = nvp_q - NV_BASE;
    nv_idx   = nv_ofs[NV_IDX_W-1:0];
    cfg_en   = ram_q[CFG_ADDR][CFG_BIT];
    erase_ok = cfg_en && nv_hit;
    if (sel_nv_q) rd_val = nv_hit ? nv_q[nv_idx] : 8'h00;
    else          rd_val = ram_q[ptr_q];
    ram_we = cmt_valid && (cmt_len == LEN_BYTE) && (cmt_cmd <= RAM_TOP);
    ptr_we = cmt_valid && (cmt_len == LEN_SEND) && (cmt_cmd <= RAM_TOP);
    nvp_we = cmt_valid && (cmt_len == LEN_WORD) && (cmt_cmd == CMD_NVPTR);
    nv_pg  = cmt_valid && (cmt_len == LEN_BYTE) && (cmt_cmd == CMD_NVPROG)
             && nv_hit && (nv_q[nv_idx] == BLANK);
    tx_we  = ev_addr && ev_rw && !erase_busy;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int i = 0; i < RAM_BYTES; i++) ram_q[i] <= 8'h00;
    end else if (ram_we) begin
      ram_q[cmt_cmd] <= cmt_d0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int i = 0; i < NV_BYTES; i++) nv_q[i] <= BLANK;
    end else if (clr_en) begin
      nv_q[clr_idx] <= BLANK;
    end else if (nv_pg) begin
      nv_q[nv_idx] <= cmt_d0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ptr_q    <= 8'h00;
      nvp_q    <= 16'h0000;
      sel_nv_q <= 1'b0;
      tx_q     <= 8'h00;
    end else begin
      if (ptr_we) begin
        ptr_q    <= cmt_cmd;
        sel_nv_q <= 1'b0;
      end else if (nvp_we) begin
        nvp_q    <= {cmt_d0, cmt_d1};
        sel_nv_q <= 1'b1;
      end
      if (tx_we) tx_q <= rd_val;
    end
  end

  assign tx_data = tx_q;

  assert_erase_gate_R8: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(erase_busy) |-> $past(cfg_en));
  assert_ram_ptr_R2: assert property (@(posedge clk) disable iff (!rst_i)
    ptr_q <= RAM_TOP);
  assert_erase_range_R7: assert property (@(posedge clk) disable iff (!rst_i)
    erase_req |-> nv_hit);

endmodule

// File: tb/smb_cmd_ctrl_bench.sv
module smb_cmd_ctrl_bench;

  localparam int CLK_NS  = 10;
  localparam int ERASE_N = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_start = 1'b0, ev_stop = 1'b0, ev_addr = 1'b0, ev_rw = 1'b0, ev_byte = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rsp_valid, rsp_ack, erase_busy;
  logic [7:0] tx_data;

  smb_cmd_ctrl #(.ERASE_CYCLES(ERASE_N)) u_smb_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_addr(ev_addr), .ev_rw(ev_rw), .ev_byte(ev_byte), .rx_data(rx_data),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .tx_data(tx_data),
    .erase_busy(erase_busy)
  );

  always #(CLK_NS / 2) clk = ~clk;

  typedef struct {
    logic       ack;
    logic       chk;
    logic [7:0] dat;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   busy_cnt = 0;
  bit   done = 1'b0;

  always @(negedge clk) begin
    if (erase_busy === 1'b1) busy_cnt++;
    if (rst_n && rsp_valid === 1'b1) begin
      n_cmp++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL %s unexpected response ack=%b expected none", "R10", rsp_ack);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_ack !== e.ack) begin
          n_bad++;
          $display("FAIL %s ack actual=%b expected=%b", e.tag, rsp_ack, e.ack);
        end else if (e.chk && tx_data !== e.dat) begin
          n_bad++;
          $display("FAIL %s data actual=%h expected=%h", e.tag, tx_data, e.dat);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic ack, input logic chk, input logic [7:0] dat, input string tag);
    exp_t e;
    e.ack = ack; e.chk = chk; e.dat = dat; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic p_start();
    @(negedge clk); ev_start = 1'b1;
    @(negedge clk); ev_start = 1'b0;
  endtask

  task automatic p_stop();
    @(negedge clk); ev_stop = 1'b1;
    @(negedge clk); ev_stop = 1'b0;
  endtask

  task automatic p_addr(input logic rw, input logic ack, input logic chk,
                        input logic [7:0] dat, input string tag);
    push(ack, chk, dat, tag);
    @(negedge clk); ev_addr = 1'b1; ev_rw = rw;
    @(negedge clk); ev_addr = 1'b0; ev_rw = 1'b0;
  endtask

  task automatic p_byte(input logic [7:0] b, input logic ack, input string tag);
    push(ack, 1'b0, 8'h00, tag);
    @(negedge clk); ev_byte = 1'b1; rx_data = b;
    @(negedge clk); ev_byte = 1'b0;
  endtask

  task automatic send_b(input logic [7:0] c, input string tag);
    p_start(); p_addr(1'b0, 1'b1, 1'b0, 8'h00, tag);
    p_byte(c, 1'b1, tag); p_stop();
  endtask

  task automatic write_b(input logic [7:0] c, input logic [7:0] d, input string tag);
    p_start(); p_addr(1'b0, 1'b1, 1'b0, 8'h00, tag);
    p_byte(c, 1'b1, tag); p_byte(d, 1'b1, tag); p_stop();
  endtask

  task automatic write_w(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b,
                         input string tag);
    p_start(); p_addr(1'b0, 1'b1, 1'b0, 8'h00, tag);
    p_byte(c, 1'b1, tag); p_byte(a, 1'b1, tag); p_byte(b, 1'b1, tag); p_stop();
  endtask

  task automatic read_b(input logic [7:0] exp, input string tag);
    p_start(); p_addr(1'b1, 1'b1, 1'b1, exp, tag); p_stop();
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle outputs and cleared register file after reset
    check("R1 rsp_valid", {7'd0, rsp_valid}, 8'h00);
    check("R1 erase_busy", {7'd0, erase_busy}, 8'h00);
    read_b(8'h00, "R1 read reg 00h");

    // R2: register write, pointer load, read back
    write_b(8'h10, 8'hA5, "R2 write 10h");
    write_b(8'h90, 8'h08, "R2 write 90h");
    send_b(8'h10, "R2 point 10h");
    read_b(8'hA5, "R2 read 10h");
    send_b(8'h90, "R2 point 90h");
    read_b(8'h08, "R2 read 90h");
    write_b(8'hDF, 8'h5C, "R2 write DFh");
    send_b(8'hDF, "R2 point DFh");
    read_b(8'h5C, "R2 read top register DFh");

    // R3: unused command values leave pointer and registers alone
    send_b(8'hE5, "R3 point E5h");
    read_b(8'h5C, "R3 pointer kept after E5h");
    write_b(8'hDF, 8'h5C, "R3 restore");
    write_b(8'hE0, 8'h33, "R3 write E0h");
    read_b(8'h5C, "R3 register DFh kept");

    // R4: word write loads non-volatile pointer, blank reads FFh
    write_w(8'hF0, 8'hF8, 8'h25, "R4 nv pointer F825h");
    read_b(8'hFF, "R4 blank reads FFh");

    // R5: program once, second program ignored
    write_b(8'hF1, 8'h3C, "R5 program 3Ch");
    read_b(8'h3C, "R5 programmed value");
    write_b(8'hF1, 8'hC3, "R5 reprogram");
    read_b(8'h3C, "R5 programmed byte not overwritten");
    write_w(8'hF0, 8'hF8, 8'h40, "R5 nv pointer F840h");
    write_b(8'hF1, 8'h77, "R5 program page 2");
    read_b(8'h77, "R5 page 2 value");

    // R6: pointer outside the window
    write_w(8'hF0, 8'hFA, 8'h00, "R6 nv pointer FA00h");
    read_b(8'h00, "R6 out of window reads 00h");
    write_b(8'hF1, 8'h11, "R6 program out of window");
    read_b(8'h00, "R6 out of window still 00h");
    write_w(8'hF0, 8'hF7, 8'hFF, "R6 nv pointer F7FFh");
    read_b(8'h00, "R6 below window reads 00h");

    // R8: erase gate closed
    write_w(8'hF0, 8'hF8, 8'h25, "R8 nv pointer F825h");
    write_b(8'h90, 8'h00, "R8 gate off");
    busy_cnt = 0;
    send_b(8'hFE, "R8 erase command");
    repeat (10) @(negedge clk);
    check("R8 no busy cycles", 8'(busy_cnt), 8'h00);
    read_b(8'h3C, "R8 data kept");

    // R7 and R9: erase with gate open, refused accesses while busy
    write_b(8'h90, 8'h08, "R7 gate on");
    busy_cnt = 0;
    send_b(8'hFE, "R7 erase command");
    p_start(); p_addr(1'b0, 1'b0, 1'b0, 8'h00, "R9 write address refused");
    p_byte(8'h10, 1'b0, "R9 byte refused"); p_stop();
    p_start(); p_addr(1'b1, 1'b0, 1'b0, 8'h00, "R9 read address refused"); p_stop();
    while (erase_busy === 1'b1) @(negedge clk);
    check("R7 busy length", 8'(busy_cnt), 8'(ERASE_N));
    read_b(8'hFF, "R7 erased byte F825h");
    write_b(8'hF1, 8'h5A, "R7 program after erase");
    read_b(8'h5A, "R7 reprogrammed after erase");
    write_w(8'hF0, 8'hF8, 8'h40, "R7 nv pointer F840h");
    read_b(8'h77, "R7 other page untouched");

    // R11: over-long write transaction discarded
    p_start(); p_addr(1'b0, 1'b1, 1'b0, 8'h00, "R11 address");
    p_byte(8'h10, 1'b1, "R11 cmd"); p_byte(8'h01, 1'b1, "R11 d0");
    p_byte(8'h02, 1'b1, "R11 d1"); p_byte(8'h03, 1'b0, "R11 fourth byte refused");
    p_stop();
    send_b(8'h10, "R11 point 10h");
    read_b(8'hA5, "R11 register 10h unchanged");

    // R10: byte outside a write transaction is refused
    p_byte(8'h10, 1'b0, "R10 stray byte refused");
    p_start(); p_addr(1'b1, 1'b1, 1'b0, 8'h00, "R10 read address ack");
    p_byte(8'h22, 1'b0, "R10 byte in read refused"); p_stop();

    repeat (4) @(negedge clk);
    n_cmp++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R10 missing responses actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule